// File: doc/BRIEF.md
# Banked 4K x 8 RAM Built from Nibble-Wide Blocks

This block is a synchronous single-port RAM. It is assembled hierarchically out of 1K-word by 4-bit storage blocks. Each storage block decodes its own 10-bit word address into one-hot word-select lines and has its own write enable. Two blocks share the low address bits and sit side by side: one holds bits 7:4 of a byte and the other holds bits 3:0. Together they form an 8-bit pair.

Depth comes from replicating pairs. A decoder on the address bits above bit 9 picks the one pair that responds. A parameter sets the number of pairs to 1, 2 or 4, and the address width follows from it. The default build has four pairs, a 12-bit address and 4096 bytes.

Read data is registered. The byte at the presented address appears one clock later. It is routed out through a multiplexer steered by a registered copy of the pair-select field. A reset synchronizer makes the asynchronous active-low reset release on a clock edge.

Top module: `nib_bank_ram`

## Requirements
- R1: While reset is held low, `rd_data` is 8'h00.
- R2: The byte stored at the address presented on a clock edge appears on `rd_data` after that edge and stays until the next edge (one cycle of read latency).
- R3: When `wr_en` is high on a clock edge, `wr_data` is stored at `addr`. Bits 7:4 go to the upper nibble block of the pair and bits 3:0 go to the lower one. A later read of that address returns the stored byte, at every address including 0, 1023, 1024 and 4095.
- R4: A write and a read of the same address on the same edge return the byte held before the write. The new byte is returned from the following read on.
- R5: Address bits 11:10 select the pair, with value 0 to 3 naming pair 0 to 3. A write changes only the selected pair, so addresses with equal bits 9:0 in different pairs hold independent bytes.
- R6: The output multiplexer follows the pair selected on the previous edge. Back-to-back reads that alternate between pairs each return their own address's byte.
- R7: With `wr_en` low, `wr_data` has no effect on any stored byte.
- R8: With the pair-count parameter set to 1, the address is 10 bits wide and all 1024 words are independently writable and readable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| addr | input | ADDR_W (12) | Byte address; the upper bits pick the pair, bits 9:0 pick the word |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Registered byte read from the previous cycle's address |

## Verification
The checker relies on a few conditions at the inputs. `wr_en` must be low while the internal reset is active. Its hold and data checks only hold from the second cycle after the synchronized reset release, because before that the read register still carries its reset value. The stimulus respects this: the bench keeps the write strobe low through reset and idles for several cycles after release before the first operation. It then changes `addr`, `wr_en` and `wr_data` only on falling edges, so each rising edge sees one stable operation.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam int unsigned BLK_AW = 10;   // word address bits inside one block
  localparam int unsigned NIB_W  = 4;    // data bits per block
  localparam int unsigned BYTE_W = 2 * NIB_W;

  // bits needed to name a pair (at least one so vectors stay legal)
  function automatic int unsigned sel_width(input int unsigned pairs);
    return (pairs > 1) ? $clog2(pairs) : 1;
  endfunction

  // address bits spent on pair selection (zero for a single pair)
  function automatic int unsigned sel_addr_bits(input int unsigned pairs);
    return (pairs > 1) ? $clog2(pairs) : 0;
  endfunction
endpackage

// File: rtl/nbr_rst_sync.sv
module nbr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/nbr_nib_block.sv
// One narrow storage block: word-select decode, gated write, registered read.
module nbr_nib_block #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] word_sel;
  logic [DW-1:0]    dout_d;

  // one-hot word-select decode
  always_comb begin
    word_sel       = '0;
    word_sel[addr] = 1'b1;
  end

  // storage: only the selected word line with we high captures din (R3, R7)
  always_ff @(posedge clk) begin
    for (int w = 0; w < DEPTH; w++) begin
      if (we && word_sel[w]) mem[w] <= din;
    end
  end

  // read of the pre-edge contents gives old data on collision (R4)
  always_comb begin
    dout_d = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= dout_d;
  end
endmodule

// File: rtl/nbr_pair_dec.sv
// Pair-select decoder: turns the upper address field into per-pair write strobes.
module nbr_pair_dec #(
  parameter int unsigned PAIRS = 4,
  parameter int unsigned SW    = 2
) (
  input  logic             wr_en,
  input  logic [SW-1:0]    sel,
  output logic [PAIRS-1:0] pair_we
);
  always_comb begin
    for (int p = 0; p < PAIRS; p++) begin
      pair_we[p] = wr_en && (sel == SW'(p));
    end
  end
endmodule

// File: rtl/nbr_rd_mux.sv
// Read-side multiplexer steered by the registered pair select.
module nbr_rd_mux #(
  parameter int unsigned PAIRS = 4,
  parameter int unsigned SW    = 2,
  parameter int unsigned DW    = 8
) (
  input  logic [SW-1:0] sel_q,
  input  logic [DW-1:0] pair_dout [PAIRS],
  output logic [DW-1:0] dout
);
  generate
    if (PAIRS == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel_q;
      assign dout = pair_dout[0];
    end else begin : g_multi
      always_comb begin
        dout = pair_dout[sel_q];
      end
    end
  endgenerate
endmodule

// File: rtl/nib_bank_ram.sv
module nib_bank_ram
  import nbr_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4,
  localparam int unsigned SEL_W  = sel_width(NUM_PAIRS),
  localparam int unsigned ADDR_W = BLK_AW + sel_addr_bits(NUM_PAIRS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data
);
  logic              rst_sync_n;
  logic [SEL_W-1:0]  blk_sel;
  logic [SEL_W-1:0]  sel_d;
  logic [SEL_W-1:0]  sel_q;
  logic [NUM_PAIRS-1:0] pair_we;
  logic [BYTE_W-1:0] pair_dout [NUM_PAIRS];

  nbr_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // pair-select field from the upper address bits (R5)
  generate
    if (NUM_PAIRS > 1) begin : g_sel
      assign blk_sel = addr[ADDR_W-1:BLK_AW];
    end else begin : g_nosel
      assign blk_sel = '0;
    end
  endgenerate

  nbr_pair_dec #(.PAIRS(NUM_PAIRS), .SW(SEL_W)) pair_dec_i (
    .wr_en   (wr_en),
    .sel     (blk_sel),
    .pair_we (pair_we)
  );

  // pairs: upper and lower nibble blocks share the word address (R3)
  generate
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      nbr_nib_block #(.AW(BLK_AW), .DW(NIB_W)) hi_blk_i (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .we    (pair_we[p]),
        .addr  (addr[BLK_AW-1:0]),
        .din   (wr_data[BYTE_W-1:NIB_W]),
        .dout  (pair_dout[p][BYTE_W-1:NIB_W])
      );
      nbr_nib_block #(.AW(BLK_AW), .DW(NIB_W)) lo_blk_i (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .we    (pair_we[p]),
        .addr  (addr[BLK_AW-1:0]),
        .din   (wr_data[NIB_W-1:0]),
        .dout  (pair_dout[p][NIB_W-1:0])
      );
    end
  endgenerate

  // registered pair select aligns the mux with the registered block outputs (R6)
  always_comb begin
    sel_d = blk_sel;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sel_q <= '0;
    else             sel_q <= sel_d;
  end

  nbr_rd_mux #(.PAIRS(NUM_PAIRS), .SW(SEL_W), .DW(BYTE_W)) rd_mux_i (
    .sel_q     (sel_q),
    .pair_dout (pair_dout),
    .dout      (rd_data)
  );
endmodule

// File: rtl/nib_bank_ram_chk.sv
module nib_bank_ram_chk #(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BYTE_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [BYTE_W-1:0]    wr_data,
  input logic [BYTE_W-1:0]    rd_data,
  input logic [NUM_PAIRS-1:0] pair_we
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RST_ZERO: assert (rd_data == '0); // R1
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pair_we)); // R5

  AST_WE_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(pair_we) == 1)); // R5

  AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (pair_we == '0)); // R7

  AST_WR_THEN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && wr_en) ##1 (!wr_en && addr == $past(addr))
      |=> (rd_data == $past(wr_data, 2))); // R3

  AST_RD_HOLD_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && !$past(wr_en) && addr == $past(addr))
      |=> $stable(rd_data)); // R4
endmodule

bind nib_bank_ram nib_bank_ram_chk #(
  .NUM_PAIRS (NUM_PAIRS),
  .ADDR_W    (ADDR_W),
  .BYTE_W    (nbr_pkg::BYTE_W)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .pair_we (pair_we)
);

// File: tb/nib_bank_ram_tb_top.sv
module nib_bank_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;

  logic        we2;
  logic [9:0]  a2;
  logic [7:0]  wd2;
  logic [7:0]  rd2;

  int total = 0;
  int bad   = 0;

  typedef struct {
    bit          chk;
    logic [7:0]  exp;
    logic [11:0] a;
    string       req;
  } item_t;

  item_t      sb_q [$];
  logic [7:0] ref_mem [int];

  always #2 clk = ~clk;

  nib_bank_ram #(.NUM_PAIRS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  nib_bank_ram #(.NUM_PAIRS(1)) small_i (
    .clk(clk), .rst_n(rst_n), .wr_en(we2), .addr(a2),
    .wr_data(wd2), .rd_data(rd2)
  );

  task automatic check(input string req, input logic [7:0] got,
                       input logic [7:0] exp, input logic [11:0] a);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", req, a, got, exp);
    end
  endtask

  // driver: one operation per cycle, expected read byte pushed to the scoreboard
  task automatic op(input logic [11:0] a, input bit we, input logic [7:0] d,
                    input string req);
    item_t it;
    @(negedge clk);
    addr = a; wr_en = we; wr_data = d;
    it.a   = a;
    it.req = req;
    it.chk = ref_mem.exists(int'(a));
    it.exp = it.chk ? ref_mem[int'(a)] : 8'h00;   // old data on collision
    if (we) ref_mem[int'(a)] = d;
    sb_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: registered read lands after the edge that follows the drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.chk) check(it.req, rd_data, it.exp, it.a);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R2 got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0;
    we2 = 1'b0; a2 = '0; wd2 = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'h00, addr);
    check("R1", rd2, 8'h00, 12'h000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3: corners of the address range
    op(12'h000, 1, 8'h3C, "R3");
    op(12'h3FF, 1, 8'hC3, "R3");
    op(12'h400, 1, 8'h96, "R3");
    op(12'hFFF, 1, 8'h69, "R3");
    op(12'h000, 0, 8'h00, "R3");
    op(12'h3FF, 0, 8'h00, "R3");
    op(12'h400, 0, 8'h00, "R3");
    op(12'hFFF, 0, 8'h00, "R3");

    // R5: same word offset in every pair holds its own byte
    for (int p = 0; p < 4; p++) op({p[1:0], 10'd5}, 1, 8'h10 + 8'(p * 17), "R5");
    for (int p = 0; p < 4; p++) op({p[1:0], 10'd5}, 0, 8'h00, "R5");

    // R7: write data with strobe low must not land
    op({2'd2, 10'd5}, 0, 8'hFF, "R7");
    op({2'd2, 10'd5}, 0, 8'h00, "R7");

    // R4: read during write returns old, the next read returns new
    op({2'd1, 10'd5}, 1, 8'hE7, "R4");
    op({2'd1, 10'd5}, 0, 8'h00, "R4");

    // R6 / R2: alternate pairs on consecutive cycles
    for (int k = 0; k < 8; k++) op({k[1:0], 10'd5}, 0, 8'h00, "R6");
    op(12'h3FF, 0, 8'h00, "R2");
    op(12'h400, 0, 8'h00, "R2");

    // mixed traffic on a small address pool
    for (int k = 0; k < 400; k++) begin
      logic [11:0] ra;
      ra = {2'($urandom), 10'($urandom % 16)};
      op(ra, ($urandom % 3) == 0, 8'($urandom), "R3");
    end
    idle();
    while (sb_q.size() > 0) @(negedge clk);

    // R8: single-pair build, 10-bit address
    @(negedge clk); a2 = 10'h3FF; we2 = 1'b1; wd2 = 8'h5A;
    @(negedge clk); a2 = 10'h000; wd2 = 8'hA5;
    @(negedge clk); we2 = 1'b0; a2 = 10'h3FF;
    @(posedge clk); #1 check("R8", rd2, 8'h5A, 12'h3FF);
    @(negedge clk); a2 = 10'h000;
    @(posedge clk); #1 check("R8", rd2, 8'hA5, 12'h000);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule